// File: doc/BRIEF.md
# Addressable LED Bit Serializer

This block drives the data line of a single-wire chain of addressable RGB LEDs. Once started, it takes 24-bit colour words from a show-ahead FIFO read port, rearranges the three colour bytes into the channel order that the LEDs on the chain expect, and sends each bit most significant first. A bit is a high phase followed by a low phase. The cycle counts for both phases are programmed separately for a 0 bit and for a 1 bit.

After the programmed number of words, the block holds the line low for a programmable reset gap. It then raises a done pulse for one cycle and returns to idle. If the FIFO runs dry in the middle of a frame, the line stays low until the next word arrives. The configuration is captured when a transfer starts, so the register file that feeds it can be rewritten while a frame is in flight.

Top module: `led_chain_serializer`

## Requirements
- R1: A word carries the red byte in bits 23:16, green in 15:8 and blue in 7:0. After reordering, bits go out most significant first. Order code 2 sends green, red, blue, and the configuration after reset uses that order.
- R2: The order code selects the byte order sent: 0 R-G-B, 1 R-B-G, 2 G-R-B, 3 G-B-R, 4 B-R-G, 5 B-G-R. Codes 6 and 7 behave as code 2.
- R3: A 1 bit drives the line high for one_hi cycles (6-bit count) and then low for one_lo cycles (5-bit count).
- R4: A 0 bit drives the line high for zero_hi cycles (5-bit count) and then low for zero_lo cycles (6-bit count).
- R5: A count of zero in any phase count, or in the gap count, gives a phase of exactly one cycle.
- R6: After the low phase of the last bit, the line stays low for gap_len cycles (13-bit count). Then done is high for exactly one cycle, and done is never high at any other time.
- R7: A frame pops exactly word_count words (13-bit count). A word_count of zero pops nothing and never drives the line high, but still produces the gap and the done pulse.
- R8: While a word is needed and the FIFO is empty, the line stays low and no pop is issued. The frame resumes when data arrives.
- R9: Order code, phase counts, gap and length are captured in the cycle a transfer starts. Changes to them, and further enable pulses, have no effect until the frame has ended.
- R10: During and after reset the line is low, done is low and no pop is issued until enable is seen.
- R11: With the FIFO non-empty, a word follows the previous one with no extra low cycle. The line goes high in the cycle after each pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; all phase counts are in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Starts a frame when seen high in idle |
| word_count | input | 13 | Number of words in the frame |
| order_sel | input | 3 | Colour byte order code |
| one_hi | input | 6 | High cycles of a 1 bit |
| one_lo | input | 5 | Low cycles of a 1 bit |
| zero_hi | input | 5 | High cycles of a 0 bit |
| zero_lo | input | 6 | Low cycles of a 0 bit |
| gap_len | input | 13 | Low cycles after the last bit |
| fifo_data | input | 24 | Head word of the FIFO, valid while not empty |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Takes the head word this cycle |
| led_out | output | 1 | Serial line to the LED chain |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Every high and low run on the line is measured and compared against the pulse widths expected from the word contents. The check covers frames of several words with asymmetric 0 and 1 timings, so that a swapped pair of counts or a wrong bit order shows up as a wrong width. One word with three distinct bytes is sent under each of the eight order codes, which separates every permutation from the others and checks the fallback for the unused codes. Further frames cover all-zero counts, full-width counts, a configuration rewrite during a transfer, a FIFO that empties between words, and a zero-length frame. These show apart the minimum-phase rule, field-width truncation, capture at start, the stall behaviour and the word counting.

// File: rtl/led_ser_pkg.sv
// Shared types and constants for the LED bit serializer.
// Assumes: one clock domain; all widths are set by the modules that use them.
package led_ser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HIGH,
        ST_LOW,
        ST_GAP,
        ST_DONE
    } ser_state_t;

    localparam int unsigned ORD_W   = 3;
    localparam logic [ORD_W-1:0] ORD_DEFAULT = 3'd2;

    // Larger of two widths, for sizing a shared counter.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/led_color_remap.sv
// Reorders the three colour bytes of a word into the order the chain expects.
// Input packing: red in the top byte, green in the middle, blue in the bottom.
// Assumes: order codes above 5 fall back to green-red-blue.
module led_color_remap #(
    parameter int unsigned CH_W = 8
) (
    input  logic [2:0]        order_sel,
    input  logic [3*CH_W-1:0] word_in,
    output logic [3*CH_W-1:0] word_out
);
    localparam int unsigned N_CH = 3;

    logic [CH_W-1:0] chan [N_CH];   // 0 = red, 1 = green, 2 = blue
    logic [1:0]      src  [N_CH];   // source channel for each output slot

    // Split the input word into its colour bytes.
    for (genvar g = 0; g < N_CH; g++) begin : g_split
        assign chan[g] = word_in[(N_CH-g)*CH_W-1 -: CH_W];
    end

    // Pick the source channel of each output slot from the order code.
    always_comb begin
        case (order_sel)
            3'd0:    begin src[0] = 2'd0; src[1] = 2'd1; src[2] = 2'd2; end
            3'd1:    begin src[0] = 2'd0; src[1] = 2'd2; src[2] = 2'd1; end
            3'd3:    begin src[0] = 2'd1; src[1] = 2'd2; src[2] = 2'd0; end
            3'd4:    begin src[0] = 2'd2; src[1] = 2'd0; src[2] = 2'd1; end
            3'd5:    begin src[0] = 2'd2; src[1] = 2'd1; src[2] = 2'd0; end
            default: begin src[0] = 2'd1; src[1] = 2'd0; src[2] = 2'd2; end
        endcase
    end

    // Assemble the reordered word, first slot in the top byte.
    for (genvar k = 0; k < N_CH; k++) begin : g_join
        assign word_out[(N_CH-k)*CH_W-1 -: CH_W] = chan[src[k]];
    end

endmodule

// File: rtl/led_phase_timer.sv
// Down-counter that times one line phase.
// A load of v makes expired go high v cycles later, so a phase lasts v+1 cycles.
// Assumes: the controller loads the count in the cycle a phase begins.
module led_phase_timer #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down and rest at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);

    // Once expired with no new load, the timer stays expired.
    assert_timer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired)
        else $error("timer left zero without a load");

    // A non-zero load is not expired in the next cycle.
    assert_timer_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired)
        else $error("timer expired right after a non-zero load");

endmodule

// File: rtl/led_frame_ctrl.sv
// Frame sequencer: fetches words, walks their bits, times each phase, then the gap.
// Assumes: show-ahead FIFO (data valid while not empty, pop takes it this cycle);
//          timing inputs are already captured for the frame; word_count is live.
module led_frame_ctrl
    import led_ser_pkg::*;
#(
    parameter int unsigned CH_W  = 8,
    parameter int unsigned LEN_W = 13,
    parameter int unsigned HI1_W = 6,
    parameter int unsigned LO1_W = 5,
    parameter int unsigned HI0_W = 5,
    parameter int unsigned LO0_W = 6,
    parameter int unsigned GAP_W = 13,
    parameter int unsigned CNT_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [LEN_W-1:0]   word_count,
    input  logic [HI1_W-1:0]   one_hi,
    input  logic [LO1_W-1:0]   one_lo,
    input  logic [HI0_W-1:0]   zero_hi,
    input  logic [LO0_W-1:0]   zero_lo,
    input  logic [GAP_W-1:0]   gap_len,
    input  logic [3*CH_W-1:0]  word_in,
    input  logic               fifo_empty,
    input  logic               tmr_expired,
    output logic               fifo_pop,
    output logic               tmr_load,
    output logic [CNT_W-1:0]   tmr_val,
    output logic               start,
    output logic               busy,
    output logic               led_out,
    output logic               done
);
    localparam int unsigned WORD_W = 3 * CH_W;
    localparam int unsigned BIT_W  = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    ser_state_t          st_q, st_d;
    logic [WORD_W-1:0]   sh_q, sh_d;
    logic [BIT_W-1:0]    bit_q, bit_d;
    logic [LEN_W-1:0]    left_q, left_d;
    logic                grab;
    logic [CNT_W-1:0]    hi1_m1, lo1_m1, hi0_m1, lo0_m1, gap_m1;

    // Count minus one, with zero held at zero so the phase lasts one cycle.
    function automatic logic [CNT_W-1:0] ph_m1(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - CNT_W'(1);
    endfunction

    assign hi1_m1 = ph_m1(CNT_W'(one_hi));
    assign lo1_m1 = ph_m1(CNT_W'(one_lo));
    assign hi0_m1 = ph_m1(CNT_W'(zero_hi));
    assign lo0_m1 = ph_m1(CNT_W'(zero_lo));
    assign gap_m1 = ph_m1(CNT_W'(gap_len));

    // Next-state logic: phase sequencing, word fetch and timer loads.
    always_comb begin
        st_d     = st_q;
        sh_d     = sh_q;
        bit_d    = bit_q;
        left_d   = left_q;
        fifo_pop = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        start    = 1'b0;
        grab     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (enable) begin
                    start  = 1'b1;
                    left_d = word_count;
                    st_d   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (left_q == '0) begin
                    tmr_load = 1'b1;
                    tmr_val  = gap_m1;
                    st_d     = ST_GAP;
                end else if (!fifo_empty) begin
                    grab = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    tmr_val  = sh_q[WORD_W-1] ? lo1_m1 : lo0_m1;
                    st_d     = ST_LOW;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    if (bit_q != '0) begin
                        sh_d     = {sh_q[WORD_W-2:0], 1'b0};
                        bit_d    = bit_q - BIT_W'(1);
                        tmr_load = 1'b1;
                        tmr_val  = sh_q[WORD_W-2] ? hi1_m1 : hi0_m1;
                        st_d     = ST_HIGH;
                    end else if (left_q == '0) begin
                        tmr_load = 1'b1;
                        tmr_val  = gap_m1;
                        st_d     = ST_GAP;
                    end else if (!fifo_empty) begin
                        grab = 1'b1;
                    end else begin
                        st_d = ST_FETCH;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired) st_d = ST_DONE;
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
        if (grab) begin
            fifo_pop = 1'b1;
            sh_d     = word_in;
            bit_d    = LAST_BIT;
            left_d   = left_q - LEN_W'(1);
            tmr_load = 1'b1;
            tmr_val  = word_in[WORD_W-1] ? hi1_m1 : hi0_m1;
            st_d     = ST_HIGH;
        end
    end

    // State, shift register, bit index and words-left registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            sh_q   <= '0;
            bit_q  <= '0;
            left_q <= '0;
        end else begin
            st_q   <= st_d;
            sh_q   <= sh_d;
            bit_q  <= bit_d;
            left_q <= left_d;
        end
    end

    assign led_out = (st_q == ST_HIGH);
    assign done    = (st_q == ST_DONE);
    assign busy    = (st_q != ST_IDLE);

    // The line goes high in the cycle after every pop.
    assert_pop_then_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> led_out)
        else $error("no high phase after a pop");

    // Waiting on an empty FIFO keeps the line low.
    assert_stall_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FETCH && fifo_empty && left_q != '0) |=> !led_out)
        else $error("line rose while starved");

    // Done lasts a single cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    // Done only follows the reset gap.
    assert_done_after_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(st_q == ST_GAP))
        else $error("done without a gap");

    // The gap is only entered with every word consumed.
    assert_gap_all_words_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GAP) |-> (left_q == '0))
        else $error("gap entered with words left");

endmodule

// File: rtl/led_chain_serializer.sv
// Top of the LED bit serializer: captures the configuration at frame start,
// reorders FIFO words and drives the single-wire line through the sequencer.
// Assumes: configuration inputs come from static registers; FIFO is show-ahead.
module led_chain_serializer
    import led_ser_pkg::*;
#(
    parameter int unsigned CH_W  = 8,
    parameter int unsigned LEN_W = 13,
    parameter int unsigned HI1_W = 6,
    parameter int unsigned LO1_W = 5,
    parameter int unsigned HI0_W = 5,
    parameter int unsigned LO0_W = 6,
    parameter int unsigned GAP_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [LEN_W-1:0]   word_count,
    input  logic [2:0]         order_sel,
    input  logic [HI1_W-1:0]   one_hi,
    input  logic [LO1_W-1:0]   one_lo,
    input  logic [HI0_W-1:0]   zero_hi,
    input  logic [LO0_W-1:0]   zero_lo,
    input  logic [GAP_W-1:0]   gap_len,
    input  logic [3*CH_W-1:0]  fifo_data,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    output logic               led_out,
    output logic               done
);
    localparam int unsigned WORD_W = 3 * CH_W;
    localparam int unsigned CNT_W  = max_u(max_u(max_u(HI1_W, LO1_W), max_u(HI0_W, LO0_W)), GAP_W);

    logic [2:0]        order_q;
    logic [HI1_W-1:0]  one_hi_q;
    logic [LO1_W-1:0]  one_lo_q;
    logic [HI0_W-1:0]  zero_hi_q;
    logic [LO0_W-1:0]  zero_lo_q;
    logic [GAP_W-1:0]  gap_q;
    logic [WORD_W-1:0] word_ord;
    logic              start, busy, tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;

    // Capture the frame configuration when a transfer starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q   <= ORD_DEFAULT;
            one_hi_q  <= '0;
            one_lo_q  <= '0;
            zero_hi_q <= '0;
            zero_lo_q <= '0;
            gap_q     <= '0;
        end else if (start) begin
            order_q   <= order_sel;
            one_hi_q  <= one_hi;
            one_lo_q  <= one_lo;
            zero_hi_q <= zero_hi;
            zero_lo_q <= zero_lo;
            gap_q     <= gap_len;
        end
    end

    led_color_remap #(.CH_W(CH_W)) u_remap (
        .order_sel (order_q),
        .word_in   (fifo_data),
        .word_out  (word_ord)
    );

    led_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    led_frame_ctrl #(
        .CH_W(CH_W), .LEN_W(LEN_W), .HI1_W(HI1_W), .LO1_W(LO1_W),
        .HI0_W(HI0_W), .LO0_W(LO0_W), .GAP_W(GAP_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .word_count  (word_count),
        .one_hi      (one_hi_q),
        .one_lo      (one_lo_q),
        .zero_hi     (zero_hi_q),
        .zero_lo     (zero_lo_q),
        .gap_len     (gap_q),
        .word_in     (word_ord),
        .fifo_empty  (fifo_empty),
        .tmr_expired (tmr_expired),
        .fifo_pop    (fifo_pop),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .start       (start),
        .busy        (busy),
        .led_out     (led_out),
        .done        (done)
    );

    // Captured configuration stays frozen while a frame runs.
    assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(order_q) && $stable(one_hi_q) && $stable(one_lo_q) &&
                  $stable(zero_hi_q) && $stable(zero_lo_q) && $stable(gap_q)))
        else $error("configuration changed during a frame");

endmodule

// File: tb/test_led_chain_serializer.sv
// Scoreboard bench: the driver queues expected (high, low) widths per bit,
// the monitor measures runs on the line and compares them.
module test_led_chain_serializer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [12:0] word_count = '0;
    logic [2:0]  order_sel = 3'd2;
    logic [5:0]  one_hi = '0;
    logic [4:0]  one_lo = '0;
    logic [4:0]  zero_hi = '0;
    logic [5:0]  zero_lo = '0;
    logic [12:0] gap_len = '0;
    logic [23:0] fifo_data = '0;
    logic        fifo_empty = 1'b1;
    logic        fifo_pop, led_out, done;

    always #4 clk = ~clk;   // 125 MHz

    led_chain_serializer i_led_chain_serializer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .word_count(word_count),
        .order_sel(order_sel), .one_hi(one_hi), .one_lo(one_lo),
        .zero_hi(zero_hi), .zero_lo(zero_lo), .gap_len(gap_len),
        .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .led_out(led_out), .done(done)
    );

    typedef struct { int hi; int lo; bit last; bit skip_lo; } exp_t;
    exp_t        exp_q[$];
    logic [23:0] fq[$];
    int checks = 0, fails = 0;
    int done_seen = 0, highs_total = 0, pops_total = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Reference byte order from the requirement table.
    function automatic logic [23:0] ref_order(input logic [23:0] w, input int code);
        logic [7:0] r, g, b;
        r = w[23:16]; g = w[15:8]; b = w[7:0];
        case (code)
            0: return {r, g, b};
            1: return {r, b, g};
            3: return {g, b, r};
            4: return {b, r, g};
            5: return {b, g, r};
            default: return {g, r, b};
        endcase
    endfunction

    // Driver side: expected widths for every bit of one word.
    task automatic queue_word(input logic [23:0] w, input int code, input bit is_last, input bit skip);
        logic [23:0] ow;
        ow = ref_order(w, code);
        for (int b = 23; b >= 0; b--) begin
            exp_t it;
            it.hi = ow[b] ? eff(int'(one_hi)) : eff(int'(zero_hi));
            it.lo = ow[b] ? eff(int'(one_lo)) : eff(int'(zero_lo));
            it.last = 1'b0;
            it.skip_lo = 1'b0;
            if (b == 0 && is_last) begin
                it.lo += eff(int'(gap_len));
                it.last = 1'b1;
            end
            if (b == 0 && skip) it.skip_lo = 1'b1;
            exp_q.push_back(it);
        end
    endtask

    // FIFO model: pop at the edge, present the head away from it.
    always @(posedge clk) begin
        if (rst_n && fifo_pop && fq.size() != 0) begin
            void'(fq.pop_front());
            pops_total++;
        end
    end
    always @(negedge clk) begin
        fifo_empty = (fq.size() == 0);
        fifo_data  = (fq.size() != 0) ? fq[0] : '0;
    end

    // Monitor: measure high/low runs and compare them with the scoreboard.
    int hi_cnt = 0, lo_cnt = 0;
    bit in_high = 1'b0, have_run = 1'b0, prev_done = 1'b0;

    task automatic compare_run(input bit at_done);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R7 extra bit on line", 1, 0);
            return;
        end
        e = exp_q.pop_front();
        check(hi_cnt == e.hi, "R1/R2/R3/R4/R5 high width", hi_cnt, e.hi);
        if (!e.skip_lo) check(lo_cnt == e.lo, "R3/R4/R6/R11 low width", lo_cnt, e.lo);
        check(at_done == e.last, "R6/R7 frame end position", int'(at_done), int'(e.last));
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            in_high = 1'b0; have_run = 1'b0; prev_done = 1'b0;
        end else begin
            if (done) begin
                check(!prev_done, "R6 done one cycle", 1, 0);
                if (have_run) compare_run(1'b1);
                have_run = 1'b0;
                in_high = 1'b0;
                done_seen++;
            end else if (led_out) begin
                if (!in_high) begin
                    if (have_run) compare_run(1'b0);
                    in_high = 1'b1; have_run = 1'b1;
                    hi_cnt = 0; lo_cnt = 0;
                    highs_total++;
                end
                hi_cnt++;
            end else begin
                in_high = 1'b0;
                if (have_run) lo_cnt++;
            end
            prev_done = done;
        end
    end

    task automatic pulse_enable();
        @(negedge clk) enable = 1'b1;
        @(negedge clk) enable = 1'b0;
    endtask

    task automatic finish_frame(input int d0, input int p0, input int nwords);
        while (done_seen == d0) @(negedge clk);
        repeat (20) @(negedge clk);
        check(done_seen == d0 + 1, "R6 one done per frame", done_seen - d0, 1);
        check(exp_q.size() == 0, "R7 all bits sent", exp_q.size(), 0);
        check(pops_total - p0 == nwords, "R7 words popped", pops_total - p0, nwords);
    endtask

    logic [23:0] wbuf [8];

    task automatic run_frame(input int n, input int code);
        int d0, p0;
        order_sel = 3'(code);
        word_count = 13'(n);
        for (int i = 0; i < n; i++) begin
            fq.push_back(wbuf[i]);
            queue_word(wbuf[i], code, i == n - 1, 1'b0);
        end
        d0 = done_seen; p0 = pops_total;
        pulse_enable();
        finish_frame(d0, p0, n);
    endtask

    task automatic set_timing(input int h1, input int l1, input int h0, input int l0, input int g);
        one_hi = 6'(h1); one_lo = 5'(l1); zero_hi = 5'(h0); zero_lo = 6'(l0); gap_len = 13'(g);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(led_out == 1'b0 && done == 1'b0 && fifo_pop == 1'b0, "R10 outputs in reset", int'(led_out | done | fifo_pop), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(led_out == 1'b0 && done == 1'b0 && fifo_pop == 1'b0, "R10 idle after reset", int'(led_out | done | fifo_pop), 0);

        // R1 R3 R4 R11: default order, three back-to-back words
        set_timing(6, 3, 3, 6, 20);
        wbuf[0] = 24'hA53C0F; wbuf[1] = 24'h00FF81; wbuf[2] = 24'h7E1802;
        run_frame(3, 2);

        // R2: every order code on one word with distinct bytes
        wbuf[0] = 24'hC3_5A_0F;
        for (int c = 0; c < 8; c++) run_frame(1, c);

        // R5: every count zero
        set_timing(0, 0, 0, 0, 0);
        wbuf[0] = 24'h813C7E; wbuf[1] = 24'h1248F0;
        run_frame(2, 4);

        // R3 R4: full-width counts
        set_timing(63, 31, 31, 63, 300);
        wbuf[0] = 24'hF00F81;
        run_frame(1, 1);

        // R9: configuration and enable changed during a frame
        begin
            int d0, p0;
            set_timing(5, 2, 2, 5, 15);
            order_sel = 3'd3; word_count = 13'd2;
            fq.push_back(24'h9966AA); fq.push_back(24'h0123EF);
            queue_word(24'h9966AA, 3, 1'b0, 1'b0);
            queue_word(24'h0123EF, 3, 1'b1, 1'b0);
            d0 = done_seen; p0 = pops_total;
            pulse_enable();
            repeat (5) @(negedge clk);
            set_timing(9, 9, 9, 9, 99);
            order_sel = 3'd5; word_count = 13'd7;
            pulse_enable();
            finish_frame(d0, p0, 2);
        end

        // R8: FIFO empties between words
        begin
            int d0, p0, h0, bad;
            set_timing(4, 2, 2, 4, 10);
            order_sel = 3'd0; word_count = 13'd2;
            fq.push_back(24'h5AA5C3);
            queue_word(24'h5AA5C3, 0, 1'b0, 1'b1);
            queue_word(24'h3C0FF0, 0, 1'b1, 1'b0);
            d0 = done_seen; p0 = pops_total; h0 = highs_total;
            pulse_enable();
            while (highs_total < h0 + 24) @(negedge clk);
            repeat (12) @(negedge clk);
            bad = 0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (led_out || fifo_pop) bad++;
            end
            check(bad == 0, "R8 line low and no pop while starved", bad, 0);
            fq.push_back(24'h3C0FF0);
            finish_frame(d0, p0, 2);
        end

        // R7: zero-length frame
        begin
            int d0, p0, h0;
            set_timing(4, 2, 2, 4, 10);
            word_count = 13'd0;
            d0 = done_seen; p0 = pops_total; h0 = highs_total;
            pulse_enable();
            finish_frame(d0, p0, 0);
            check(highs_total == h0, "R7 zero length never high", highs_total - h0, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule